// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is a clock-slave receive port for two-channel serial audio. An external master supplies the bit clock, the word-select (channel) clock and the serial data. All three arrive as plain inputs. The block never drives a clock. It brings the three lines into the system clock domain through a synchroniser, detects each rising edge of the bit clock, and samples the data line on that edge. Each channel word is 16 bits, two's complement, with the most significant bit first.

Three framing variants are selected at run time by a two-bit format input:

- **Left-justified:** the word starts on the first bit clock after a word-select change.
- **Delayed (I2S style):** the word starts one bit clock later than in left-justified framing.
- **Right-justified:** the word ends on the last bit clock before the next word-select change.

Each word-select half-period carries one channel. Once a left word and then the matching right word have been captured, the block presents both words in parallel and raises a one-cycle valid pulse. The outputs hold their values until the next pulse. The system clock must run at least four times faster than the bit clock.

Top module: `serial_audio_rx`

## Requirements
- R1: While rst_ni is low, left_o and right_o read zero and pair_valid_o is low.
- R2: With fmt_i = 2'b00 (left-justified), bit positions 0 to 15 of a half-frame form the word, MSB first. Position 0 is the first bit-clock rising edge at which the new word-select level is seen.
- R3: With fmt_i = 2'b01 or 2'b11 (delayed), bit positions 1 to 15+1 form the word, MSB first. Position 0 carries the LSB of the previous word.
- R4: With fmt_i = 2'b10 (right-justified), the 16 bits sampled on the last 16 bit-clock rising edges before a word-select change form the word of the half-frame that is ending. The final bit is the LSB.
- R5: Bits beyond the 16 word positions are ignored in the left-justified and delayed formats. Bits ahead of the final 16 are ignored in the right-justified format.
- R6: In the delayed format, word-select low marks the left channel, whatever the value of left_high_i. In the other two formats, the left channel is the word-select level equal to left_high_i.
- R7: pair_valid_o pulses for exactly one cycle when a right word completes after a left word. A right word that completes with no left word stored since the last pulse gives no pulse.
- R8: left_o and right_o change only in the cycle in which pair_valid_o is high.
- R9: pair_valid_o and the new data appear on the fourth rising system-clock edge after the bit-clock rise that completes the right word. That rise is the last word bit in the left-justified and delayed formats, and the word-select change in the right-justified format.
- R10: Bits received before the first word-select change seen after reset are discarded and never form part of an output pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word-select (channel) clock |
| sd_i | input | 1 | External serial data |
| fmt_i | input | 2 | Framing: 00 left-justified, 01/11 delayed, 10 right-justified |
| left_high_i | input | 1 | Word-select level marking left in the non-delayed formats |
| left_o | output | 16 | Left word of the last completed pair |
| right_o | output | 16 | Right word of the last completed pair |
| pair_valid_o | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
**Latency.** Every result is due a fixed four system clocks after the bit-clock rise that completes it. Two cycles go to the synchroniser, one to edge detection and word capture, and one to pair assembly.

**How the bench keeps to it.** The bench derives the bit clock from the system clock, at eight system clocks per bit, and drives it just after a system-clock edge. A monitor samples on the falling system-clock edge and counts samples since each observed bit-clock rise. Every pulse must therefore arrive at a count of exactly four. Checks on missing or suppressed pairs are taken only after at least ten idle cycles following the last bit, so any late pulse would already have been recorded.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_DLY = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_ALT = 2'b11
  } fmt_e;

  function automatic logic fmt_delayed(input fmt_e f);
    return (f == FMT_DLY) || (f == FMT_ALT);
  endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sar_word_cap.sv
module sar_word_cap
  import sar_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  fmt_e              fmt_i,
  input  logic              left_high_i,
  output logic              rise_o,
  output logic              word_vld_o,
  output logic              word_right_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sck_q, ws_q, primed_q, synced_q;
  logic [CNT_W-1:0]  pos_q, cur, first, last;
  logic [WORD_W-1:0] sh_q;
  logic              delayed, is_rj, trans, synced_now, take;
  logic              done_fix, done_rj, left_lvl;

  assign rise_o     = sck_i & ~sck_q;
  assign delayed    = fmt_delayed(fmt_i);
  assign is_rj      = (fmt_i == FMT_RJ);
  assign first      = delayed ? CNT_W'(1) : '0;
  assign last       = first + CNT_W'(WORD_W - 1);
  assign trans      = rise_o & primed_q & (ws_i != ws_q);
  assign synced_now = synced_q | trans;
  assign cur        = trans ? '0 : pos_q;
  assign take       = rise_o & synced_now & ~is_rj & (cur >= first) & (cur <= last);
  assign done_fix   = take & (cur == last);
  // right-justified word closes on the change, before the new bit shifts in
  assign done_rj    = trans & synced_q & is_rj;
  assign left_lvl   = delayed ? 1'b0 : left_high_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q        <= 1'b0;
      ws_q         <= 1'b0;
      primed_q     <= 1'b0;
      synced_q     <= 1'b0;
      pos_q        <= '0;
      sh_q         <= '0;
      word_vld_o   <= 1'b0;
      word_right_o <= 1'b0;
      word_o       <= '0;
    end else begin
      sck_q      <= sck_i;
      word_vld_o <= 1'b0;
      if (rise_o) begin
        primed_q <= 1'b1;
        ws_q     <= ws_i;
        pos_q    <= (cur == CNT_MAX) ? cur : cur + CNT_W'(1);
        if (trans) synced_q <= 1'b1;
      end
      if (take || (rise_o && is_rj)) sh_q <= {sh_q[WORD_W-2:0], sd_i};
      if (done_rj) begin
        word_o       <= sh_q;
        word_right_o <= (ws_q != left_lvl);
        word_vld_o   <= 1'b1;
      end
      if (done_fix) begin
        word_o       <= {sh_q[WORD_W-2:0], sd_i};
        word_right_o <= (ws_i != left_lvl);
        word_vld_o   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sar_pair.sv
module sar_pair #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic              word_right_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              pair_valid_o
);

  logic [WORD_W-1:0] left_hold_q;
  logic              have_left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q  <= '0;
      have_left_q  <= 1'b0;
      left_o       <= '0;
      right_o      <= '0;
      pair_valid_o <= 1'b0;
    end else begin
      pair_valid_o <= 1'b0;
      if (word_vld_i) begin
        if (!word_right_i) begin
          left_hold_q <= word_i;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o       <= left_hold_q;
          right_o      <= word_i;
          pair_valid_o <= 1'b1;
          have_left_q  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic              left_high_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              pair_valid_o
);

  localparam int LINES = 3;

  logic [LINES-1:0]  line_s;
  logic              bit_rise, word_vld, word_right;
  logic [WORD_W-1:0] word;

  sar_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sd_i, ws_i, sck_i}),
    .q_o   (line_s)
  );

  sar_word_cap #(.WORD_W(WORD_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (line_s[0]),
    .ws_i        (line_s[1]),
    .sd_i        (line_s[2]),
    .fmt_i       (fmt_e'(fmt_i)),
    .left_high_i (left_high_i),
    .rise_o      (bit_rise),
    .word_vld_o  (word_vld),
    .word_right_o(word_right),
    .word_o      (word)
  );

  sar_pair #(.WORD_W(WORD_W)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_vld_i  (word_vld),
    .word_right_i(word_right),
    .word_i      (word),
    .left_o      (left_o),
    .right_o     (right_o),
    .pair_valid_o(pair_valid_o)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pair_valid_o,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              bit_rise,
  input logic              word_vld,
  input logic              word_right
);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |=> !pair_valid_o);

  a_r7_from_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> $past(word_vld && word_right));

  a_r8_hold_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |-> $stable(left_o));

  a_r8_hold_right: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pair_valid_o |-> $stable(right_o));

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_valid_o |-> $past(bit_rise, 2));

endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pair_valid_o(pair_valid_o),
  .left_o      (left_o),
  .right_o     (right_o),
  .bit_rise    (bit_rise),
  .word_vld    (word_vld),
  .word_right  (word_right)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        left_high = 1'b1;
  logic [15:0] left_o, right_o;
  logic        pair_valid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] got_l[8], got_r[8], exp_l[8], exp_r[8];
  int          got_lat[8];
  int          got_n = 0, since = 100, hold_err = 0;
  logic        bclk_q = 1'b0, rst_q = 1'b0;
  logic [15:0] last_l = '0, last_r = '0;

  always #10 clk = ~clk;

  serial_audio_rx dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(bclk), .ws_i(lrclk), .sd_i(sdata),
    .fmt_i(fmt), .left_high_i(left_high),
    .left_o(left_o), .right_o(right_o), .pair_valid_o(pair_valid_o)
  );

  always @(negedge clk) begin
    if (bclk && !bclk_q) since = 0;
    else if (since < 100) since++;
    bclk_q = bclk;
    if (pair_valid_o && got_n < 8) begin
      got_l[got_n] = left_o; got_r[got_n] = right_o; got_lat[got_n] = since;
      got_n++;
    end
    if (rst_ni && rst_q && !pair_valid_o && (left_o != last_l || right_o != last_r)) hold_err++;
    last_l = left_o; last_r = right_o; rst_q = rst_ni;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] wgen(input int i);
    return 16'((i * 12071 + 32768) & 16'hFFFF);
  endfunction

  function automatic logic gen(input int k, input int nb, input logic [15:0] w,
                               input logic [15:0] prev, input bit junk);
    case (fmt)
      2'b00:   return (k < 16) ? w[15-k] : junk;
      2'b10:   return (k >= nb - 16) ? w[15-(k-(nb-16))] : junk;
      default: return (k == 0) ? prev[0] : ((k <= 16) ? w[16-k] : junk);
    endcase
  endfunction

  task automatic bit_out(input logic ws, input logic b);
    @(posedge clk); lrclk <= ws; sdata <= b; bclk <= 1'b0;
    repeat (3) @(posedge clk);
    @(posedge clk); bclk <= 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic half(input logic ws, input logic [15:0] w, input logic [15:0] prev,
                      input int nb, input bit junk);
    for (int k = 0; k < nb; k++) bit_out(ws, gen(k, nb, w, prev, junk));
  endtask

  task automatic do_reset(input logic ws);
    @(posedge clk);
    rst_ni <= 1'b0; bclk <= 1'b0; lrclk <= ws; sdata <= 1'b0;
    repeat (3) @(posedge clk);
    rst_ni <= 1'b1;
    @(posedge clk);
    got_n = 0;
  endtask

  // lead-in half, nf left/right frames, trailing half, then compare
  task automatic play(input logic [1:0] f, input logic lh, input int nf, input int nb,
                      input bit junk, input int seed, input string tag);
    logic        lvl;
    logic [15:0] prev;
    fmt = f; left_high = lh;
    lvl = (f == 2'b01 || f == 2'b11) ? 1'b0 : lh;
    do_reset(~lvl);
    half(~lvl, 16'h5A5A, 16'h0, nb, junk);
    prev = 16'h5A5A;
    for (int i = 0; i < nf; i++) begin
      exp_l[i] = wgen(seed + 2 * i);
      exp_r[i] = wgen(seed + 2 * i + 1);
      half(lvl, exp_l[i], prev, nb, junk);  prev = exp_l[i];
      half(~lvl, exp_r[i], prev, nb, junk); prev = exp_r[i];
    end
    half(lvl, 16'h0, prev, nb, junk);
    repeat (10) @(posedge clk);
    chk(got_n == nf, {tag, " pair count"}, got_n, nf);
    for (int i = 0; i < nf && i < got_n; i++) begin
      chk(got_l[i] == exp_l[i], {tag, " left word"}, got_l[i], exp_l[i]);
      chk(got_r[i] == exp_r[i], {tag, " right word"}, got_r[i], exp_r[i]);
      chk(got_lat[i] == 4, "R9 latency", got_lat[i], 4);
    end
    if (nf > 0) begin
      chk(left_o == exp_l[nf-1], "R8 left held", left_o, exp_l[nf-1]);
      chk(right_o == exp_r[nf-1], "R8 right held", right_o, exp_r[nf-1]);
    end
    chk(hold_err == 0, "R8 change without pulse", hold_err, 0);
  endtask

  task automatic t_reset;
    @(posedge clk); rst_ni <= 1'b0;
    repeat (2) @(negedge clk);
    chk(left_o == 16'h0, "R1 left", left_o, 0);
    chk(right_o == 16'h0, "R1 right", right_o, 0);
    chk(pair_valid_o == 1'b0, "R1 valid", pair_valid_o, 0);
  endtask

  task automatic t_left_just;  play(2'b00, 1'b1, 3, 16, 1'b0, 1, "R2"); endtask
  task automatic t_delayed;    play(2'b01, 1'b1, 3, 17, 1'b0, 9, "R3 R6"); endtask
  task automatic t_alt_code;   play(2'b11, 1'b0, 2, 17, 1'b1, 21, "R3"); endtask
  task automatic t_right_just; play(2'b10, 1'b1, 3, 16, 1'b0, 33, "R4"); endtask
  task automatic t_surplus_lj; play(2'b00, 1'b1, 2, 24, 1'b1, 47, "R5 lj"); endtask
  task automatic t_surplus_dl; play(2'b01, 1'b1, 2, 24, 1'b1, 55, "R5 dly"); endtask
  task automatic t_surplus_rj; play(2'b10, 1'b1, 2, 24, 1'b1, 63, "R5 rj"); endtask
  task automatic t_polarity;   play(2'b00, 1'b0, 2, 16, 1'b0, 71, "R6"); endtask

  task automatic t_orphan;
    fmt = 2'b00; left_high = 1'b1;
    do_reset(1'b1);
    half(1'b1, 16'h1234, 16'h0, 16, 1'b0);  // lead-in left, before any change
    half(1'b0, 16'h4321, 16'h0, 16, 1'b0);  // right with no stored left
    repeat (10) @(posedge clk);
    chk(got_n == 0, "R10 R7 no pair from lead-in", got_n, 0);
    half(1'b1, 16'hC3C3, 16'h0, 16, 1'b0);
    half(1'b0, 16'h3C3C, 16'h0, 16, 1'b0);
    half(1'b1, 16'h0, 16'h0, 16, 1'b0);
    repeat (10) @(posedge clk);
    chk(got_n == 1, "R7 single pair", got_n, 1);
    chk(got_l[0] == 16'hC3C3, "R7 left", got_l[0], 16'hC3C3);
    chk(got_r[0] == 16'h3C3C, "R7 right", got_r[0], 16'h3C3C);
  endtask

  initial begin
    t_reset();
    t_left_just();
    t_delayed();
    t_alt_code();
    t_right_just();
    t_surplus_lj();
    t_surplus_dl();
    t_surplus_rj();
    t_polarity();
    t_orphan();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule